// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block is a real-time clock core. It holds the date and time as six BCD bytes: seconds, minutes, hours (24-hour), day of month, month (01-12) and two-digit year (00-99, meaning 2000-2099). A 32768 Hz tick arrives as a single-cycle enable in the system clock domain. A prescaler divides it down to one time update per second. Each update carries through every field, honouring month lengths and leap years.

Software works through a small byte-wide register port. Writes take effect on the next clock edge and reads are combinational. Through this port software sets and reads the time, programs a one-shot alarm and starts or stops the counter. It also reads and clears the event flags. A busy indication warns that an update is imminent. A time write that lands inside that window is held back and applied after the update, so neither the write nor the carry is lost. Two interrupt outputs report the once-per-second event and the alarm match, each behind its own enable.

Register map (4-bit address): 0-5 time fields (0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year); 6 control; 7 interrupt enable; 8-13 alarm fields in the same order as the time fields; 15 status. Address 14 reads as zero.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. Control, interrupt enable and status all read 0x00, and both interrupt outputs are low.
- R2: While control bit 0 is 1, the seconds field advances once every DIV_COUNT ticks. Seconds roll from 59 to 00 with a carry into minutes, minutes roll from 59 to 00 with a carry into hours, and hours roll from 23 to 00 with a carry into the day.
- R3: While control bit 0 is 0, the time does not change and the prescaler holds its count. Status bit 1 reads the value of control bit 0.
- R4: The day rolls over to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and 28 or 29 for month 02. Month rolls from 12 to 01 with a carry into the year, and year rolls from 99 to 00.
- R5: A year whose value is divisible by 4 (00 included) gives February 29 days; any other year gives 28.
- R6: Status bit 0 (busy) is high only while running, and only during the final tick period before an update. It is low in the cycle after the update.
- R7: A time-field write outside busy takes effect on the next clock. A time-field write while busy is held and applied after the update, so the field reads the written value and not that value plus a carry.
- R8: Status bit 6 is set by an update whose new time equals all six alarm fields. A difference in any single field (the day, for example) prevents the match.
- R9: Status bit 2 is set by every update.
- R10: Writing status with a 1 in bit 6 or bit 2 clears that flag. A 0 in that position leaves the flag unchanged.
- R11: irq_alarm equals status bit 6 AND enable bit 3. irq_timer equals status bit 2 AND enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle pulse at the 32768 Hz rate |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_timer | output | 1 | Once-per-second interrupt, gated by enable bit 2 |
| irq_alarm | output | 1 | Alarm interrupt, gated by enable bit 3 |

## Verification
The bench builds the core with DIV_COUNT = 4 and pulses the tick every third clock, so one second lasts twelve clocks. The time can then be preloaded just before a day, month, year or leap-day boundary, and the carry is seen after a single step. The busy window is three clocks wide, which leaves room for the bench to see it and then land a time write inside it. This shows that the deferred write survives the concurrent carry.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  localparam int NFIELD = 6;
  typedef logic [NFIELD-1:0][7:0] rtc_time_t;

  localparam int F_SEC = 0;
  localparam int F_MIN = 1;
  localparam int F_HR  = 2;
  localparam int F_DAY = 3;
  localparam int F_MON = 4;
  localparam int F_YR  = 5;

  localparam logic [3:0] A_CTRL = 4'd6;
  localparam logic [3:0] A_IEN  = 4'd7;
  localparam logic [3:0] A_STAT = 4'd15;

  localparam int ST_BUSY = 0;
  localparam int ST_RUN  = 1;
  localparam int ST_SEC  = 2;
  localparam int ST_ALM  = 6;
  localparam int IE_TMR  = 2;
  localparam int IE_ALM  = 3;

  // {wrap, next}: BCD increment that returns to 'first' at or past 'last'
  function automatic logic [8:0] bcd_step(logic [7:0] v, logic [7:0] last, logic [7:0] first);
    logic [7:0] n;
    if (v >= last) return {1'b1, first};
    if (v[3:0] >= 4'd9) n = {v[7:4] + 4'd1, 4'd0};
    else                n = {v[7:4], v[3:0] + 4'd1};
    return {1'b0, n};
  endfunction

  function automatic logic [6:0] bcd_bin(logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(logic [7:0] y);
    logic [6:0] b;
    b = bcd_bin(y);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(logic [7:0] m, logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic rtc_time_t rtc_advance(rtc_time_t t);
    rtc_time_t  r;
    logic [8:0] s;
    logic       c;
    r = t;
    s = bcd_step(t[F_SEC], 8'h59, 8'h00); r[F_SEC] = s[7:0]; c = s[8];
    if (c) begin s = bcd_step(t[F_MIN], 8'h59, 8'h00); r[F_MIN] = s[7:0]; c = s[8]; end
    if (c) begin s = bcd_step(t[F_HR], 8'h23, 8'h00); r[F_HR] = s[7:0]; c = s[8]; end
    if (c) begin
      s = bcd_step(t[F_DAY], month_last(t[F_MON], t[F_YR]), 8'h01);
      r[F_DAY] = s[7:0]; c = s[8];
    end
    if (c) begin s = bcd_step(t[F_MON], 8'h12, 8'h01); r[F_MON] = s[7:0]; c = s[8]; end
    if (c) begin s = bcd_step(t[F_YR], 8'h99, 8'h00); r[F_YR] = s[7:0]; end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic busy,
  output logic update
);
  localparam int CW = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_COUNT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (run && tick) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  // busy covers the final tick period before the carry
  assign busy   = run && (cnt == LAST);
  assign update = busy && tick;

  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> !busy) else $error("busy outlived update"); // R6
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt)) else $error("prescaler moved while stopped"); // R3
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       update,
  input  logic       busy,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  output rtc_time_t  now,
  output rtc_time_t  nxt
);
  localparam rtc_time_t RST_TIME = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [7:0]        fld_d [NFIELD];
  logic [NFIELD-1:0] pend_v;
  logic [NFIELD-1:0] wr_now;

  assign nxt = rtc_advance(now);

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    logic       pv;
    logic [7:0] pd;
    logic       hit, direct, apply;
    assign hit    = wr_en && (wr_idx == 3'(i));
    assign direct = hit && !busy;
    assign apply  = pv && !busy && !direct;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pv <= 1'b0;
        pd <= 8'h00;
      end else if (hit && busy) begin
        pv <= 1'b1;
        pd <= wr_data;
      end else if (direct || apply) begin
        pv <= 1'b0;
      end
    end

    assign fld_d[i]  = update ? nxt[i] : direct ? wr_data : apply ? pd : now[i];
    assign pend_v[i] = pv;
    assign wr_now[i] = direct || apply;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) now <= RST_TIME;
    else for (int k = 0; k < NFIELD; k++) now[k] <= fld_d[k];
  end

  AST_TIME_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!update && wr_now == '0) |=> $stable(now)) else $error("time moved without cause"); // R3
  AST_DEFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> pend_v != '0) else $error("busy write dropped"); // R7
  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v != '0 && !busy) |=> pend_v == '0) else $error("held write not applied"); // R7
endmodule

// File: rtl/rtc_alarm.sv
`timescale 1ns/1ps
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  input  rtc_time_t  cand,
  output rtc_time_t  alarm,
  output logic       match
);
  logic [NFIELD-1:0] eq;

  always_ff @(posedge clk) begin
    if (!rst_n) alarm <= '0;
    else if (wr_en)
      for (int k = 0; k < NFIELD; k++)
        if (wr_idx == 3'(k)) alarm[k] <= wr_data;
  end

  // every field must agree; no field can be masked
  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    assign eq[i] = (cand[i] == alarm[i]);
  end
  assign match = &eq;
endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       bus_wr,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_timer,
  output logic       irq_alarm
);
  logic      run, ien_tmr, ien_alm, flag_sec, flag_alm;
  logic      busy, update, match;
  logic      wr_time, wr_alm, wr_stat;
  rtc_time_t now, nxt, alarm;

  assign wr_time = bus_wr && (bus_addr < 4'd6);
  assign wr_alm  = bus_wr && (bus_addr >= 4'd8) && (bus_addr <= 4'd13);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);

  rtc_prescaler #(.DIV_COUNT(DIV_COUNT)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick_32k),
    .busy(busy), .update(update)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .update(update), .busy(busy),
    .wr_en(wr_time), .wr_idx(bus_addr[2:0]), .wr_data(bus_wdata),
    .now(now), .nxt(nxt)
  );

  rtc_alarm u_alm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_alm), .wr_idx(bus_addr[2:0]),
    .wr_data(bus_wdata), .cand(nxt), .alarm(alarm), .match(match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ien_tmr  <= 1'b0;
      ien_alm  <= 1'b0;
      flag_sec <= 1'b0;
      flag_alm <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) run <= bus_wdata[0];
      if (bus_wr && bus_addr == A_IEN) begin
        ien_tmr <= bus_wdata[IE_TMR];
        ien_alm <= bus_wdata[IE_ALM];
      end
      if (update)                         flag_sec <= 1'b1;
      else if (wr_stat && bus_wdata[ST_SEC]) flag_sec <= 1'b0;
      if (update && match)                flag_alm <= 1'b1;
      else if (wr_stat && bus_wdata[ST_ALM]) flag_alm <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5:
        for (int k = 0; k < NFIELD; k++) if (bus_addr[2:0] == 3'(k)) bus_rdata = now[k];
      4'd8, 4'd9, 4'd10, 4'd11, 4'd12, 4'd13:
        for (int k = 0; k < NFIELD; k++) if (bus_addr[2:0] == 3'(k)) bus_rdata = alarm[k];
      A_CTRL: bus_rdata = {7'b0, run};
      A_IEN:  bus_rdata = {4'b0, ien_alm, ien_tmr, 2'b0};
      A_STAT: bus_rdata = {1'b0, flag_alm, 3'b000, flag_sec, run, busy};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_timer = flag_sec && ien_tmr;
  assign irq_alarm = flag_alm && ien_alm;

  AST_ALARM_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_alm) |-> $past(update)) else $error("alarm flag without update"); // R8
  AST_SEC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_sec) |-> $past(update)) else $error("second flag without update"); // R9
  AST_ALARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[ST_ALM] && !(update && match)) |=> !flag_alm)
    else $error("alarm flag not cleared"); // R10
  AST_RUN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run) else $error("busy while stopped"); // R6
endmodule

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;
  localparam int DIV = 4;
  localparam int GAP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_timer, irq_alarm;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bcd_rtc_core #(.DIV_COUNT(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_timer(irq_timer), .irq_alarm(irq_alarm)
  );

  initial begin
    int g = 0;
    forever begin
      @(negedge clk);
      g = g + 1;
      tick = (g % GAP == 0);
    end
  end

  typedef struct {
    logic [3:0] a;
    logic [7:0] m;
    logic [7:0] e;
    string      tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic push_exp(input logic [3:0] a, input logic [7:0] m, input logic [7:0] e, input string tag);
    exp_t x;
    x.a = a; x.m = m; x.e = e; x.tag = tag;
    sb.push_back(x);
  endtask

  // monitor side of the scoreboard: pops each expectation and compares
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t x;
      logic [7:0] d;
      x = sb.pop_front();
      bus_read(x.a, d);
      check(x.tag, d & x.m, x.e);
    end
  endtask

  task automatic exp_time(input logic [7:0] y, mo, dy, h, mi, s, input string tag);
    push_exp(4'd5, 8'hFF, y, tag);
    push_exp(4'd4, 8'hFF, mo, tag);
    push_exp(4'd3, 8'hFF, dy, tag);
    push_exp(4'd2, 8'hFF, h, tag);
    push_exp(4'd1, 8'hFF, mi, tag);
    push_exp(4'd0, 8'hFF, s, tag);
  endtask

  task automatic set_time(input logic [7:0] y, mo, dy, h, mi, s);
    bus_write(4'd5, y); bus_write(4'd4, mo); bus_write(4'd3, dy);
    bus_write(4'd2, h); bus_write(4'd1, mi); bus_write(4'd0, s);
  endtask

  task automatic poll_status(input logic [7:0] mask, output bit ok);
    logic [7:0] d;
    ok = 1'b0;
    for (int i = 0; i < 200 && !ok; i++) begin
      @(negedge clk);
      bus_read(4'd15, d);
      if ((d & mask) != 8'h00) ok = 1'b1;
    end
  endtask

  // run until one update has happened, then stop
  task automatic step_one(input string tag);
    bit ok;
    bus_write(4'd15, 8'h04);
    bus_write(4'd6, 8'h01);
    poll_status(8'h04, ok);
    bus_write(4'd6, 8'h00);
    check({tag, " update seen"}, {7'b0, ok}, 8'h01);
  endtask

  task automatic carry_case(input logic [7:0] y, mo, dy, h, mi, s,
                            input logic [7:0] ey, emo, edy, eh, emi, es, input string tag);
    set_time(y, mo, dy, h, mi, s);
    step_one(tag);
    exp_time(ey, emo, edy, eh, emi, es, tag);
    drain();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [7:0] d0, d1;
    int t0, t1;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    exp_time(8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R1 reset time");
    push_exp(4'd6, 8'hFF, 8'h00, "R1 reset control");
    push_exp(4'd7, 8'hFF, 8'h00, "R1 reset enable");
    push_exp(4'd15, 8'hFF, 8'h00, "R1 reset status");
    drain();
    check("R1 irq_timer", {7'b0, irq_timer}, 8'h00);
    check("R1 irq_alarm", {7'b0, irq_alarm}, 8'h00);

    // R7 write outside busy lands next clock
    bus_write(4'd1, 8'h42);
    bus_read(4'd1, d0);
    check("R7 direct write", d0, 8'h42);

    // R2 digit carry and hour carry
    carry_case(8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h09,
               8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h10, "R2 digit carry");
    carry_case(8'h21, 8'h06, 8'h15, 8'h10, 8'h59, 8'h59,
               8'h21, 8'h06, 8'h15, 8'h11, 8'h00, 8'h00, "R2 hour carry");
    // R5 leap years, R4 month lengths and year wrap
    carry_case(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59,
               8'h24, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, "R5 leap 24");
    carry_case(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59,
               8'h24, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R4 leap feb end");
    carry_case(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59,
               8'h23, 8'h03, 8'h01, 8'h00, 8'h00, 8'h00, "R5 common year");
    carry_case(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59,
               8'h00, 8'h02, 8'h29, 8'h00, 8'h00, 8'h00, "R5 leap 00");
    carry_case(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59,
               8'h21, 8'h05, 8'h01, 8'h00, 8'h00, 8'h00, "R4 30-day");
    carry_case(8'h21, 8'h07, 8'h30, 8'h23, 8'h59, 8'h59,
               8'h21, 8'h07, 8'h31, 8'h00, 8'h00, 8'h00, "R4 31-day mid");
    carry_case(8'h21, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59,
               8'h21, 8'h02, 8'h01, 8'h00, 8'h00, 8'h00, "R4 31-day end");
    carry_case(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59,
               8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, "R4 year wrap");

    // R2 one update per DIV ticks
    bus_write(4'd6, 8'h01);
    bus_write(4'd15, 8'h04);
    poll_status(8'h04, ok);
    t0 = cyc;
    bus_write(4'd15, 8'h04);
    poll_status(8'h04, ok);
    t1 = cyc;
    check("R2 period", 8'(t1 - t0), 8'(DIV * GAP));
    bus_read(4'd15, d0);
    check("R3 run bit", d0 & 8'h02, 8'h02);
    bus_write(4'd6, 8'h00);

    // R3 frozen when stopped
    bus_read(4'd0, d0);
    repeat (50) @(negedge clk);
    bus_read(4'd0, d1);
    check("R3 frozen", d1, d0);
    bus_read(4'd15, d0);
    check("R3 run bit low", d0 & 8'h03, 8'h00);

    // R6/R7 write inside busy window is deferred
    set_time(8'h21, 8'h06, 8'h15, 8'h10, 8'h20, 8'h00);
    bus_write(4'd15, 8'h04);
    bus_write(4'd6, 8'h01);
    poll_status(8'h01, ok);
    check("R6 busy seen", {7'b0, ok}, 8'h01);
    bus_write(4'd0, 8'h30);
    poll_status(8'h04, ok);
    bus_read(4'd15, d0);
    check("R6 busy low after update", d0 & 8'h01, 8'h00);
    bus_write(4'd6, 8'h00);
    push_exp(4'd0, 8'hFF, 8'h30, "R7 deferred seconds");
    push_exp(4'd1, 8'hFF, 8'h20, "R7 minutes kept");
    drain();

    // R8 alarm match, R11 gating, R10 clear
    set_time(8'h10, 8'h05, 8'h15, 8'h12, 8'h30, 8'h45);
    bus_write(4'd8, 8'h46); bus_write(4'd9, 8'h30); bus_write(4'd10, 8'h12);
    bus_write(4'd11, 8'h15); bus_write(4'd12, 8'h05); bus_write(4'd13, 8'h10);
    bus_write(4'd7, 8'h08);
    bus_write(4'd15, 8'h44);
    step_one("R8 alarm run");
    push_exp(4'd15, 8'h40, 8'h40, "R8 alarm flag");
    drain();
    check("R11 irq_alarm on", {7'b0, irq_alarm}, 8'h01);
    check("R11 irq_timer masked", {7'b0, irq_timer}, 8'h00);
    bus_write(4'd15, 8'h04);
    push_exp(4'd15, 8'h44, 8'h40, "R10 zero leaves alarm");
    drain();
    bus_write(4'd15, 8'h40);
    push_exp(4'd15, 8'h40, 8'h00, "R10 alarm cleared");
    drain();
    check("R11 irq_alarm off", {7'b0, irq_alarm}, 8'h00);

    // R8 one differing field blocks the match
    set_time(8'h10, 8'h05, 8'h15, 8'h12, 8'h30, 8'h45);
    bus_write(4'd11, 8'h16);
    bus_write(4'd15, 8'h44);
    step_one("R8 mismatch run");
    push_exp(4'd15, 8'h40, 8'h00, "R8 day mismatch");
    drain();
    check("R11 irq_alarm idle", {7'b0, irq_alarm}, 8'h00);

    // R9 second flag, R11 timer irq, R10 clear
    bus_write(4'd7, 8'h04);
    bus_write(4'd15, 8'h44);
    step_one("R9 timer run");
    push_exp(4'd15, 8'h04, 8'h04, "R9 second flag");
    drain();
    check("R11 irq_timer on", {7'b0, irq_timer}, 8'h01);
    bus_write(4'd15, 8'h04);
    push_exp(4'd15, 8'h04, 8'h00, "R10 second cleared");
    drain();
    check("R11 irq_timer off", {7'b0, irq_timer}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule